// File: doc/BRIEF.md
# UART Register Front End with Internal Loopback

This block holds the register state of a 16550-style serial port and moves characters between a 16-bit register bus and a byte-wide character interface. Each bus access is one cycle. A request carries an address, a size code and a write flag. Read data and the error code are combinational for that cycle, and every register effect takes place on the clock edge that ends it. Serial bit timing, baud generation and FIFOs sit outside the block. Downstream logic takes bytes through a push strobe and returns them through a pop strobe with a valid flag.

Two registers share their addresses with the divisor latch. A divisor-access bit in the line-control register selects which one an access reaches. An internal loopback mode cuts off the receive input. In that mode a transmitted byte goes into a one-entry holding register, and the next receive read returns it. Event pulses for transmit and receive are gated by interrupt-enable bits. The receive event comes from a periodic poll whose period is set by a parameter.

Top module: `uart_regfile`

## Requirements
- R1: Registers sit on a 4-byte stride. Index = byte offset / 4, offset bits [1:0] must be zero. Valid indices are 0 (data), 1 (enable), 2 (ident), 3 (line control), 4 (modem control), 5 (line status), 7 (scratch) and 9 (global control). Index 6, index 8, indices above 9 and misaligned offsets return error code 2 and have no side effect.
- R2: Only `bus_size` = 1 (16-bit) is accepted. Any other size returns error code 1, even when the address is also invalid.
- R3: When line-control bit 7 is set, index 0 reaches divisor-low and index 1 reaches divisor-high. When it is clear, they reach the data register and the enable register.
- R4: After reset, divisor-low reads 0x0001, ident reads 0x0001, stored line status is 0x0060, and every other register is zero.
- R5: Writes to ident and line status are ignored. Line control, modem control, scratch and global control are plain 16-bit read/write storage.
- R6: A line-status read returns the stored bits ORed with the live status, then clears the stored bits to zero.
- R7: A data write with modem-control bit 4 (loopback) set pushes the byte to the TX interface and also puts it in the holding register, marked valid.
- R8: A data read does one of three things. It returns the held byte and clears the valid flag if a byte is held. Otherwise, under loopback, it returns the previous received byte without popping. Otherwise it pops and returns `rx_data` if `rx_valid` is set, and returns the previous byte if not.
- R9: A data write with enable bit 1 set makes `tx_evt` high for exactly the cycle after the write.
- R10: While enable bit 0 is set, a poll fires every POLL_CYCLES cycles, counted from the write that set the bit. Each poll that sees data-ready raises `rx_evt` for one cycle. Clearing the bit stops the polling.
- R11: Live status sets bit 0 (data ready) when a byte is held, or when `rx_valid` is set and loopback is off. Bits 5 and 6 both follow `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_err | output | 2 | 0 = ok, 1 = size error, 2 = invalid register |
| tx_data | output | 8 | Byte being pushed |
| tx_push | output | 1 | Push strobe |
| tx_ready | input | 1 | Transmitter idle and empty |
| rx_data | input | 8 | Next received byte |
| rx_valid | input | 1 | Received byte available |
| rx_pop | output | 1 | Pop strobe |
| tx_evt | output | 1 | Transmit event pulse |
| rx_evt | output | 1 | Receive event pulse |

## Verification
The bench checks the corner cases that a faulty decoder or status path would get wrong. An access that is both the wrong size and at an invalid offset must report a size error, so swapping the two error checks shows up as code 2. A second line-status read with the transmitter busy must return zero. A design that is not destructive would keep returning 0x0060. Under loopback, a design that fails to disconnect the receive input would pop `rx_data` and return 0x77 instead of the held or previous byte. The receive poll is timed to the exact cycle from the enabling write. The bench also checks that no event is raised once data-ready drops or the enable bit clears.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int ADDR_W      = 6,
  parameter int POLL_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [1:0]        bus_err,
  output logic [7:0]        tx_data,
  output logic              tx_push,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_pop,
  output logic              tx_evt,
  output logic              rx_evt
);
  localparam int IW = ADDR_W - 2;
  localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;

  logic [15:0] div_lo, div_hi, ien, ident, lctl, mctl, lstat, scratch, gctrl;
  logic [7:0]  rbr_q, hold_b;
  logic        hold_v, tx_evt_q, rx_evt_q;
  logic [CW-1:0] poll_cnt;

  wire [IW-1:0] idx     = bus_addr[ADDR_W-1:2];
  wire          aligned = bus_addr[1:0] == 2'b00;
  wire          reg_ok  = aligned && idx <= IW'(9) && idx != IW'(6) && idx != IW'(8);

  assign bus_err = !bus_req ? 2'd0 : (bus_size != 2'd1) ? 2'd1 : !reg_ok ? 2'd2 : 2'd0;

  wire go     = bus_req && bus_err == 2'd0;
  wire wr     = go && bus_we;
  wire rd     = go && !bus_we;
  wire dlab   = lctl[7];
  wire loop   = mctl[4];
  wire thr_wr = wr && idx == IW'(0) && !dlab;
  wire rbr_rd = rd && idx == IW'(0) && !dlab;
  wire lsr_rd = rd && idx == IW'(5);
  wire dr     = hold_v || (!loop && rx_valid);
  wire poll_hit = ien[0] && poll_cnt == CW'(POLL_CYCLES - 1);

  wire [15:0] live     = {9'b0, tx_ready, tx_ready, 4'b0, dr};
  wire [7:0]  rbr_next = hold_v ? hold_b : (!loop && rx_valid) ? rx_data : rbr_q;

  assign tx_push = thr_wr;
  assign tx_data = bus_wdata[7:0];
  assign rx_pop  = rbr_rd && !hold_v && !loop && rx_valid;
  assign tx_evt  = tx_evt_q;
  assign rx_evt  = rx_evt_q;

  always_comb begin
    bus_rdata = 16'h0000;
    if (rd) begin
      case (idx)
        IW'(0):  bus_rdata = dlab ? div_lo : {8'h00, rbr_next};
        IW'(1):  bus_rdata = dlab ? div_hi : ien;
        IW'(2):  bus_rdata = ident;
        IW'(3):  bus_rdata = lctl;
        IW'(4):  bus_rdata = mctl;
        IW'(5):  bus_rdata = lstat | live;
        IW'(7):  bus_rdata = scratch;
        IW'(9):  bus_rdata = gctrl;
        default: bus_rdata = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo   <= 16'h0001;
      div_hi   <= '0;
      ien      <= '0;
      ident    <= 16'h0001;
      lctl     <= '0;
      mctl     <= '0;
      lstat    <= 16'h0060;
      scratch  <= '0;
      gctrl    <= '0;
      rbr_q    <= '0;
      hold_b   <= '0;
      hold_v   <= 1'b0;
      tx_evt_q <= 1'b0;
      rx_evt_q <= 1'b0;
      poll_cnt <= '0;
    end else begin
      if (wr) begin
        case (idx)
          IW'(0): if (dlab) div_lo <= bus_wdata;
          IW'(1): if (dlab) div_hi <= bus_wdata; else ien <= bus_wdata;
          IW'(3): lctl    <= bus_wdata;
          IW'(4): mctl    <= bus_wdata;
          IW'(7): scratch <= bus_wdata;
          IW'(9): gctrl   <= bus_wdata;
          default: ;
        endcase
      end
      if (thr_wr && loop) begin
        hold_b <= bus_wdata[7:0];
        hold_v <= 1'b1;
      end
      if (rbr_rd) begin
        rbr_q  <= rbr_next;
        hold_v <= 1'b0;
      end
      if (lsr_rd) lstat <= '0;
      tx_evt_q <= thr_wr && ien[1];
      rx_evt_q <= poll_hit && dr;
      if (!ien[0] || poll_hit) poll_cnt <= '0;
      else                     poll_cnt <= poll_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic [1:0] bus_size,
  input logic [1:0] bus_err,
  input logic       tx_push,
  input logic       tx_evt,
  input logic       rx_pop,
  input logic       rx_valid,
  input logic       rx_evt
);
  AST_SIZE_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size != 2'd1 |-> bus_err == 2'd1); // R2
  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err != 2'd0 |-> !tx_push && !rx_pop); // R1
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_valid); // R8
  AST_TX_EVT_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |-> $past(tx_push)); // R9
  AST_RX_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> !rx_evt); // R10
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_size(bus_size),
  .bus_err(bus_err), .tx_push(tx_push), .tx_evt(tx_evt), .rx_pop(rx_pop),
  .rx_valid(rx_valid), .rx_evt(rx_evt)
);

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;
  localparam int P = 16;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [5:0] bus_addr = 0;
  logic [1:0] bus_size = 1;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [1:0] bus_err;
  logic [7:0] tx_data, rx_data = 0;
  logic tx_push, tx_ready = 1, rx_valid = 0, rx_pop, tx_evt, rx_evt;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  uart_regfile #(.ADDR_W(6), .POLL_CYCLES(P)) i_uart_regfile (.*);

  logic [15:0] s_rd; logic [1:0] s_err; logic s_push, s_pop, s_tevt; logic [7:0] s_txd;

  task automatic acc(input logic we, input logic [5:0] a, input logic [1:0] sz, input logic [15:0] wd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    #1;
    s_rd = bus_rdata; s_err = bus_err; s_push = tx_push; s_pop = rx_pop; s_txd = tx_data;
    @(posedge clk); #1;
    bus_req = 0;
    s_tevt = tx_evt;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {we, addr, size, wdata, exp_err, exp_rdata}
  localparam logic [42:0] VEC [21] = '{
    {1'b0, 6'h08, 2'd1, 16'h0000, 2'd0, 16'h0001}, // R4 ident
    {1'b0, 6'h14, 2'd1, 16'h0000, 2'd0, 16'h0060}, // R4 R6
    {1'b0, 6'h14, 2'd1, 16'h0000, 2'd0, 16'h0060}, // R6 live only
    {1'b1, 6'h0C, 2'd1, 16'h0080, 2'd0, 16'h0000}, // R3 set divisor access
    {1'b0, 6'h00, 2'd1, 16'h0000, 2'd0, 16'h0001}, // R3 R4 divisor-low
    {1'b1, 6'h04, 2'd1, 16'h1234, 2'd0, 16'h0000}, // R3
    {1'b0, 6'h04, 2'd1, 16'h0000, 2'd0, 16'h1234}, // R3
    {1'b1, 6'h0C, 2'd1, 16'h0003, 2'd0, 16'h0000}, // R5
    {1'b0, 6'h04, 2'd1, 16'h0000, 2'd0, 16'h0000}, // R3 enable untouched
    {1'b1, 6'h1C, 2'd1, 16'hBEEF, 2'd0, 16'h0000}, // R5
    {1'b0, 6'h1C, 2'd1, 16'h0000, 2'd0, 16'hBEEF}, // R5
    {1'b1, 6'h24, 2'd1, 16'h0001, 2'd0, 16'h0000}, // R5
    {1'b0, 6'h24, 2'd1, 16'h0000, 2'd0, 16'h0001}, // R5
    {1'b1, 6'h08, 2'd1, 16'hFFFF, 2'd0, 16'h0000}, // R5
    {1'b0, 6'h08, 2'd1, 16'h0000, 2'd0, 16'h0001}, // R5 ident ignored write
    {1'b0, 6'h18, 2'd1, 16'h0000, 2'd2, 16'h0000}, // R1 index 6
    {1'b1, 6'h20, 2'd1, 16'h0000, 2'd2, 16'h0000}, // R1 index 8
    {1'b0, 6'h28, 2'd1, 16'h0000, 2'd2, 16'h0000}, // R1 index 10
    {1'b0, 6'h02, 2'd1, 16'h0000, 2'd2, 16'h0000}, // R1 misaligned
    {1'b0, 6'h08, 2'd0, 16'h0000, 2'd1, 16'h0000}, // R2
    {1'b0, 6'h20, 2'd2, 16'h0000, 2'd1, 16'h0000}  // R2 priority
  };

  task automatic do_reset();
    rst_n = 0; repeat (3) @(posedge clk); #1; rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first;
    logic seen;
    do_reset();
    for (int i = 0; i < 21; i++) begin
      logic [42:0] v;
      v = VEC[i];
      acc(v[42], v[41:36], v[35:34], v[33:18]);
      chk($sformatf("R1/R2 err vec%0d", i), s_err, v[17:16]);
      if (!v[42] && v[17:16] == 2'd0) chk($sformatf("R3/R4/R5/R6 rdata vec%0d", i), s_rd, v[15:0]);
    end

    do_reset();
    tx_ready = 0; rx_valid = 0;
    acc(0, 6'h14, 1, 0); chk("R6 first read", s_rd, 16'h0060);
    acc(0, 6'h14, 1, 0); chk("R6 cleared", s_rd, 16'h0000);
    acc(1, 6'h14, 1, 16'hFFFF);
    acc(0, 6'h14, 1, 0); chk("R5 status write ignored", s_rd, 16'h0000);
    tx_ready = 1; rx_valid = 1; rx_data = 8'h77;
    acc(0, 6'h14, 1, 0); chk("R11 rx data ready", s_rd, 16'h0061);
    acc(1, 6'h10, 1, 16'h0010);
    acc(0, 6'h14, 1, 0); chk("R11 loop hides rx", s_rd, 16'h0060);
    acc(1, 6'h00, 1, 16'h005A);
    chk("R7 push", s_push, 1); chk("R7 data", s_txd, 8'h5A); chk("R9 no evt", s_tevt, 0);
    acc(0, 6'h14, 1, 0); chk("R11 held ready", s_rd, 16'h0061);
    acc(0, 6'h00, 1, 0); chk("R8 held byte", s_rd, 16'h005A); chk("R8 no pop", s_pop, 0);
    acc(0, 6'h00, 1, 0); chk("R8 loop keeps", s_rd, 16'h005A); chk("R8 loop no pop", s_pop, 0);
    acc(1, 6'h10, 1, 16'h0000);
    acc(0, 6'h00, 1, 0); chk("R8 pop rx", s_rd, 16'h0077); chk("R8 pop strobe", s_pop, 1);
    acc(1, 6'h04, 1, 16'h0002);
    acc(1, 6'h00, 1, 16'h0011); chk("R9 tx evt", s_tevt, 1);
    @(posedge clk); #1; chk("R9 one cycle", tx_evt, 0);

    acc(1, 6'h04, 1, 16'h0001);
    first = 0;
    for (int k = 1; k <= 3 * P; k++) begin
      @(posedge clk); #1;
      if (rx_evt && first == 0) first = k;
    end
    chk("R10 poll period", first, P);
    rx_valid = 0; seen = 0;
    repeat (3 * P) begin @(posedge clk); #1; seen |= rx_evt; end
    chk("R10 no data no evt", seen, 0);
    rx_valid = 1;
    acc(1, 6'h04, 1, 16'h0000);
    seen = 0;
    repeat (3 * P) begin @(posedge clk); #1; seen |= rx_evt; end
    chk("R10 disabled", seen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule